// File: doc/BRIEF.md
# Accumulator ALU and Execute Decoder

This block is the execute stage of a small 8-bit accumulator machine. It takes a 13-bit instruction word, the current accumulator, the data read from the addressed register and the present carry flag. In a single combinational step it works out which register-group operation the word encodes, computes the result, and says where the result goes. It also reports which of the zero, carry and digit-carry flags change, with their new values, and whether the next instruction is to be skipped.

The surrounding core owns the register file, the flags, the program counter and fetch. It applies `wr_en` and `to_regfile` to steer the result into the accumulator or into the register at `insn[5:0]`. It loads each flag whose enable is high and advances the program counter past one extra word when `skip` is high. Because the block holds no state and has no stream-shaped data path, it has no handshake and no clock. Every output settles from the present inputs.

Top module: `acc_exec_unit`

## Requirements
- R1: A word with `insn[12]=1` produces no write, no flag enable and no skip. The same applies to any word in the group `insn[11:6]=000000` other than `0x0001`, and to `insn[11:6]=000010` with `insn[5:0]` not zero.
- R2: For register-group words with `insn[11]=0`, `insn[6]` picks the destination: 0 means accumulator (`to_regfile=0`) and 1 means register file (`to_regfile=1`).
- R3: Add (`insn[11:7]=00111`) yields (R+A) mod 256. C is the carry out of bit 7 and DC the carry out of bit 3, and Z, C and DC are all enabled.
- R4: Subtract (`insn[11:7]=00010`) yields R−A. C is 1 when R≥A (no borrow) and DC is 1 when R[3:0]≥A[3:0], and Z, C and DC are all enabled.
- R5: OR (`00100`), AND (`00101`), XOR (`00110`), move R (`01000`) and complement R (`01001`) in `insn[11:7]` form the named function of A and R. Only Z is enabled.
- R6: Increment (`01010`) and decrement (`00011`) in `insn[11:7]` yield R+1 and R−1 modulo 256. Only Z is enabled.
- R7: `insn[11:6]=000001` writes A to the register file with no flag change. `0x0080` and `insn[11:6]=000011` write zero to the accumulator and to the register respectively, with Z enabled and equal to 1.
- R8: Rotate right (`insn[11:7]=01100`) yields {C, R[7:1]} with new C = R[0]. Rotate left (`01101`) yields {R[6:0], C} with new C = R[7]. Only C is enabled.
- R9: Swap (`insn[11:7]=01110`) yields {R[3:0], R[7:4]} and enables no flag.
- R10: Decrement-skip (`01011`) and increment-skip (`01111`) in `insn[11:7]` yield R−1 and R+1. They enable no flag and raise `skip` exactly when the result is zero.
- R11: With `insn[12:11]=01`, `insn[10:9]` selects 00 clear bit, 01 set bit, 10 skip if bit is 0, 11 skip if bit is 1, on bit index `insn[8:6]` of R. Clear and set write the register file. The two tests write nothing. None of the four enables a flag.
- R12: Decimal adjust (`0x0001`) adds 0x06 when A[3:0]>9 and adds 0x60 when C=1 or A>0x99, writing the accumulator. New C is 1 exactly when the 0x60 correction applies, and only C is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 13 | Instruction word being executed |
| acc_in | input | 8 | Current accumulator value |
| rdata | input | 8 | Read data of the register addressed by insn[5:0] |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Value to write |
| to_regfile | output | 1 | 1: write goes to register file, 0: to accumulator |
| wr_en | output | 1 | Result is to be written |
| z_flag | output | 1 | New zero flag |
| z_we | output | 1 | Load z_flag |
| c_flag | output | 1 | New carry flag |
| c_we | output | 1 | Load c_flag |
| dc_flag | output | 1 | New digit-carry flag |
| dc_we | output | 1 | Load dc_flag |
| skip | output | 1 | Skip the next instruction |

## Verification
The bound assertions assume only that all four inputs are driven to known levels. They stay silent while any input bit is unknown, and they judge each operation from its encoding alone, with no prior state. The bench therefore holds the inputs at a defined no-operation word through reset. It changes inputs only on falling clock edges and reads outputs a quarter period later, after the combinational path has settled. Operand values are chosen to hit each carry, borrow, nibble and zero boundary.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int INSN_W  = 13;
  localparam int DATA_W  = 8;
  localparam int RADDR_W = 6;
  localparam int NIB_W   = DATA_W / 2;
  localparam int BIDX_W  = $clog2(DATA_W);
  localparam int GRP_W   = 4;

  typedef enum logic [4:0] {
    X_NONE, X_MOVA, X_CLR, X_SUB, X_DEC, X_OR, X_AND, X_XOR, X_ADD,
    X_MOV, X_COM, X_INC, X_DJZ, X_RRC, X_RLC, X_SWAP, X_JZ, X_DAA,
    X_BCLR, X_BSET, X_BTST0, X_BTST1
  } xop_e;

  typedef struct packed {
    xop_e              op;
    logic              to_reg;
    logic [BIDX_W-1:0] bidx;
  } xctl_t;
endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output xctl_t             ctl
);
  localparam int BANK_BIT  = INSN_W - 1;
  localparam int BITOP_BIT = INSN_W - 2;
  localparam int DIR_BIT   = RADDR_W;

  logic [GRP_W-1:0]   grp;
  logic [RADDR_W-1:0] raddr;
  logic               dir;

  assign grp   = insn[BITOP_BIT-1 -: GRP_W];
  assign raddr = insn[RADDR_W-1:0];
  assign dir   = insn[DIR_BIT];

  always_comb begin
    ctl.op     = X_NONE;
    ctl.to_reg = dir;
    ctl.bidx   = insn[RADDR_W +: BIDX_W];
    if (!insn[BANK_BIT]) begin
      if (insn[BITOP_BIT]) begin
        case (insn[BITOP_BIT-1 -: 2])
          2'b00:   ctl.op = X_BCLR;
          2'b01:   ctl.op = X_BSET;
          2'b10:   ctl.op = X_BTST0;
          default: ctl.op = X_BTST1;
        endcase
        ctl.to_reg = 1'b1;
      end else begin
        case (grp)
          4'd0: begin
            if (dir) ctl.op = X_MOVA;
            else if (raddr == RADDR_W'(1)) ctl.op = X_DAA;
          end
          4'd1: begin
            if (dir) ctl.op = X_CLR;
            else if (raddr == '0) ctl.op = X_CLR;
          end
          4'd2:    ctl.op = X_SUB;
          4'd3:    ctl.op = X_DEC;
          4'd4:    ctl.op = X_OR;
          4'd5:    ctl.op = X_AND;
          4'd6:    ctl.op = X_XOR;
          4'd7:    ctl.op = X_ADD;
          4'd8:    ctl.op = X_MOV;
          4'd9:    ctl.op = X_COM;
          4'd10:   ctl.op = X_INC;
          4'd11:   ctl.op = X_DJZ;
          4'd12:   ctl.op = X_RRC;
          4'd13:   ctl.op = X_RLC;
          4'd14:   ctl.op = X_SWAP;
          default: ctl.op = X_JZ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acc_exec_arith.sv
module acc_exec_arith
  import acc_exec_pkg::*;
(
  input  xop_e              op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdat,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              hout
);
  localparam logic [NIB_W-1:0] NIB_MAX_BCD = NIB_W'(9);
  localparam logic [NIB_W-1:0] NIB_FIX     = NIB_W'(6);
  localparam logic [DATA_W-1:0] BYTE_MAX_BCD = {NIB_MAX_BCD, NIB_MAX_BCD};

  logic [DATA_W-1:0] opb;
  logic              ci;
  logic [NIB_W:0]    lo_sum;
  logic [NIB_W:0]    hi_sum;
  logic              lo_fix, hi_fix;
  logic [DATA_W-1:0] daa_adj;

  always_comb begin
    opb = acc;
    ci  = 1'b0;
    case (op)
      X_SUB:        begin opb = ~acc; ci = 1'b1; end
      X_INC, X_JZ:  begin opb = '0;   ci = 1'b1; end
      X_DEC, X_DJZ: begin opb = '1;   ci = 1'b0; end
      default:      begin opb = acc;  ci = 1'b0; end
    endcase
  end

  // Two nibble-wide stages expose the digit carry without a second adder
  assign lo_sum = {1'b0, rdat[NIB_W-1:0]} + {1'b0, opb[NIB_W-1:0]} + (NIB_W+1)'(ci);
  assign hi_sum = {1'b0, rdat[DATA_W-1:NIB_W]} + {1'b0, opb[DATA_W-1:NIB_W]}
                + (NIB_W+1)'(lo_sum[NIB_W]);

  assign lo_fix  = acc[NIB_W-1:0] > NIB_MAX_BCD;
  assign hi_fix  = cin | (acc > BYTE_MAX_BCD);
  assign daa_adj = {(hi_fix ? NIB_FIX : '0), (lo_fix ? NIB_FIX : '0)};

  always_comb begin
    if (op == X_DAA) begin
      res  = acc + daa_adj;
      cout = hi_fix;
      hout = 1'b0;
    end else begin
      res  = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
      cout = hi_sum[NIB_W];
      hout = lo_sum[NIB_W];
    end
  end
endmodule

// File: rtl/acc_exec_logic.sv
module acc_exec_logic
  import acc_exec_pkg::*;
(
  input  xop_e              op,
  input  logic [BIDX_W-1:0] bidx,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdat,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              bit_val
);
  logic [DATA_W-1:0] bsel;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bsel
    assign bsel[gi] = (bidx == BIDX_W'(gi));
  end

  assign bit_val = |(rdat & bsel);

  always_comb begin
    res  = rdat;
    cout = cin;
    case (op)
      X_OR:    res = rdat | acc;
      X_AND:   res = rdat & acc;
      X_XOR:   res = rdat ^ acc;
      X_MOV:   res = rdat;
      X_MOVA:  res = acc;
      X_COM:   res = ~rdat;
      X_CLR:   res = '0;
      X_RRC:   begin res = {cin, rdat[DATA_W-1:1]}; cout = rdat[0]; end
      X_RLC:   begin res = {rdat[DATA_W-2:0], cin}; cout = rdat[DATA_W-1]; end
      X_SWAP:  res = {rdat[NIB_W-1:0], rdat[DATA_W-1:NIB_W]};
      X_BCLR:  res = rdat & ~bsel;
      X_BSET:  res = rdat | bsel;
      default: res = rdat;
    endcase
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] rdata,
  input  logic              c_in,
  output logic [DATA_W-1:0] result,
  output logic              to_regfile,
  output logic              wr_en,
  output logic              z_flag,
  output logic              z_we,
  output logic              c_flag,
  output logic              c_we,
  output logic              dc_flag,
  output logic              dc_we,
  output logic              skip
);
  xctl_t             ctl;
  logic [DATA_W-1:0] ar_res, lg_res;
  logic              ar_c, ar_h, lg_c, bit_val;
  logic              use_arith;

  acc_exec_decode u_dec (.insn(insn), .ctl(ctl));

  acc_exec_arith u_arith (
    .op(ctl.op), .acc(acc_in), .rdat(rdata), .cin(c_in),
    .res(ar_res), .cout(ar_c), .hout(ar_h)
  );

  acc_exec_logic u_logic (
    .op(ctl.op), .bidx(ctl.bidx), .acc(acc_in), .rdat(rdata), .cin(c_in),
    .res(lg_res), .cout(lg_c), .bit_val(bit_val)
  );

  assign use_arith = ctl.op inside {X_ADD, X_SUB, X_INC, X_DEC, X_JZ, X_DJZ, X_DAA};
  assign result    = use_arith ? ar_res : lg_res;
  assign z_flag    = ~|result;
  assign c_flag    = use_arith ? ar_c : lg_c;
  assign dc_flag   = ar_h;

  always_comb begin
    wr_en = 1'b1;
    z_we  = 1'b0;
    c_we  = 1'b0;
    dc_we = 1'b0;
    skip  = 1'b0;
    case (ctl.op)
      X_NONE:  wr_en = 1'b0;
      X_BTST0: begin wr_en = 1'b0; skip = ~bit_val; end
      X_BTST1: begin wr_en = 1'b0; skip = bit_val; end
      X_ADD, X_SUB: begin z_we = 1'b1; c_we = 1'b1; dc_we = 1'b1; end
      X_OR, X_AND, X_XOR, X_MOV, X_COM, X_INC, X_DEC, X_CLR: z_we = 1'b1;
      X_RRC, X_RLC, X_DAA: c_we = 1'b1;
      X_DJZ, X_JZ: skip = ~|result;
      default: ;
    endcase
  end

  assign to_regfile = wr_en & ctl.to_reg;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
  import acc_exec_pkg::*;
(
  input logic [INSN_W-1:0] insn,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] rdata,
  input logic              c_in,
  input logic [DATA_W-1:0] result,
  input logic              to_regfile,
  input logic              wr_en,
  input logic              z_flag,
  input logic              z_we,
  input logic              c_flag,
  input logic              c_we,
  input logic              dc_flag,
  input logic              dc_we,
  input logic              skip
);
  logic [DATA_W:0] add_ref;
  logic            known;

  assign add_ref = (DATA_W+1)'(acc_in) + (DATA_W+1)'(rdata);
  assign known   = !$isunknown({insn, acc_in, rdata, c_in});

  always_comb begin
    if (known) begin
      if (insn[12]) begin
        // R1
        bank_noop_chk: assert (!wr_en && !z_we && !c_we && !dc_we && !skip)
          else $error("upper-bank word caused an effect");
      end
      if (insn[12:7] == 6'b000111) begin
        // R3
        add_sum_chk: assert ({c_flag, result} == add_ref && z_we && c_we && dc_we
                             && dc_flag == (add_ref[4] ^ acc_in[4] ^ rdata[4])
                             && z_flag == (add_ref[7:0] == '0)
                             && to_regfile == insn[6])
          else $error("add result or flags wrong");
      end
      if (insn[12:7] == 6'b000010) begin
        // R4
        sub_borrow_chk: assert (result == DATA_W'(rdata - acc_in)
                                && c_flag == (rdata >= acc_in) && c_we)
          else $error("subtract result or borrow wrong");
      end
      if (insn[12:7] == 6'b001100) begin
        // R8
        rotate_carry_chk: assert (c_flag == rdata[0] && result[7] == c_in
                                  && c_we && !z_we && !dc_we)
          else $error("rotate right carry path wrong");
      end
      if (insn[12:7] == 6'b001110) begin
        // R9
        swap_quiet_chk: assert (result == {rdata[3:0], rdata[7:4]}
                                && !z_we && !c_we && !dc_we && !skip)
          else $error("swap changed flags or data wrong");
      end
      if (insn[12:10] == 3'b011) begin
        // R11
        bit_test_chk: assert (!wr_en && !z_we && !c_we && !dc_we
                              && skip == (rdata[insn[8:6]] == insn[9]))
          else $error("bit test wrote or skipped wrongly");
      end
    end
  end
endmodule

bind acc_exec_unit acc_exec_chk u_chk (
  .insn(insn), .acc_in(acc_in), .rdata(rdata), .c_in(c_in),
  .result(result), .to_regfile(to_regfile), .wr_en(wr_en),
  .z_flag(z_flag), .z_we(z_we), .c_flag(c_flag), .c_we(c_we),
  .dc_flag(dc_flag), .dc_we(dc_we), .skip(skip)
);

// File: tb/tb_acc_exec_unit.sv
module tb_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] insn = 13'h0000;
  logic [7:0]  acc_in = 8'h00;
  logic [7:0]  rdata = 8'h00;
  logic        c_in = 1'b0;
  logic [7:0]  result;
  logic        to_regfile, wr_en, z_flag, z_we, c_flag, c_we, dc_flag, dc_we, skip;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_exec_unit dut (
    .insn(insn), .acc_in(acc_in), .rdata(rdata), .c_in(c_in),
    .result(result), .to_regfile(to_regfile), .wr_en(wr_en),
    .z_flag(z_flag), .z_we(z_we), .c_flag(c_flag), .c_we(c_we),
    .dc_flag(dc_flag), .dc_we(dc_we), .skip(skip)
  );

  function automatic logic [12:0] rop(input logic [4:0] op5, input logic d, input logic [5:0] ra);
    return {1'b0, op5[4:0], d, ra};
  endfunction

  function automatic logic [12:0] bop(input logic [1:0] k, input logic [2:0] b, input logic [5:0] ra);
    return {2'b01, k, b, ra};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] i, input logic [7:0] a, input logic [7:0] r, input logic c);
    @(negedge clk);
    insn = i; acc_in = a; rdata = r; c_in = c;
    #5;
  endtask

  task automatic expect_out(input string req, input logic we, input logic dst, input logic [7:0] res,
                            input logic zw, input logic z, input logic cw, input logic c,
                            input logic dw, input logic dc, input logic sk);
    chk(req, "wr_en", 16'(wr_en), 16'(we));
    if (we) begin
      chk(req, "to_regfile", 16'(to_regfile), 16'(dst));
      chk(req, "result", 16'(result), 16'(res));
    end
    chk(req, "z_we", 16'(z_we), 16'(zw));
    if (zw) chk(req, "z_flag", 16'(z_flag), 16'(z));
    chk(req, "c_we", 16'(c_we), 16'(cw));
    if (cw) chk(req, "c_flag", 16'(c_flag), 16'(c));
    chk(req, "dc_we", 16'(dc_we), 16'(dw));
    if (dw) chk(req, "dc_flag", 16'(dc_flag), 16'(dc));
    chk(req, "skip", 16'(skip), 16'(sk));
  endtask

  task automatic t_reset;
    #5;
    expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_noop;
    apply(13'h1000 | 13'h0123, 8'h55, 8'hAA, 1); // call-like upper bank
    expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(13'h1C00, 8'h00, 8'h00, 0);
    expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(13'h0002, 8'h12, 8'h34, 0);
    expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(13'h0081, 8'h12, 8'h34, 0); // malformed clear-accumulator
    expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_add(input logic d, input logic [7:0] a, input logic [7:0] r);
    logic [8:0] s;
    logic [4:0] h;
    s = {1'b0, a} + {1'b0, r};
    h = {1'b0, a[3:0]} + {1'b0, r[3:0]};
    apply(rop(5'b00111, d, 6'h05), a, r, 1);
    expect_out("R3", 1, d, s[7:0], 1, s[7:0] == 0, 1, s[8], 1, h[4], 0);
  endtask

  task automatic t_add;
    do_add(0, 8'h3C, 8'h0F);
    do_add(1, 8'h80, 8'h80);
    do_add(1, 8'h01, 8'h02);
  endtask

  task automatic do_sub(input logic d, input logic [7:0] a, input logic [7:0] r);
    logic [7:0] e;
    e = r - a;
    apply(rop(5'b00010, d, 6'h11), a, r, 0);
    expect_out("R4", 1, d, e, 1, e == 0, 1, r >= a, 1, r[3:0] >= a[3:0], 0);
  endtask

  task automatic t_sub;
    do_sub(0, 8'h20, 8'h50);
    do_sub(1, 8'h01, 8'h10);
    do_sub(0, 8'h05, 8'h05);
    do_sub(1, 8'h03, 8'h02);
  endtask

  task automatic t_logic;
    apply(rop(5'b00100, 0, 6'h01), 8'hF0, 8'h0C, 0);
    expect_out("R5", 1, 0, 8'hFC, 1, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b00101, 1, 6'h01), 8'hF0, 8'h0C, 0);
    expect_out("R5", 1, 1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    apply(rop(5'b00110, 0, 6'h01), 8'hFF, 8'h0F, 0);
    expect_out("R5", 1, 0, 8'hF0, 1, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b01000, 1, 6'h01), 8'h99, 8'h00, 1);
    expect_out("R5", 1, 1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    apply(rop(5'b01001, 0, 6'h01), 8'h00, 8'h5A, 0);
    expect_out("R5", 1, 0, 8'hA5, 1, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b01000, 0, 6'h02), 8'h00, 8'h7E, 0); // R2 direction to accumulator
    expect_out("R2", 1, 0, 8'h7E, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_incdec;
    apply(rop(5'b01010, 1, 6'h03), 8'h00, 8'hFF, 0);
    expect_out("R6", 1, 1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    apply(rop(5'b00011, 0, 6'h03), 8'h00, 8'h00, 0);
    expect_out("R6", 1, 0, 8'hFF, 1, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b00011, 1, 6'h03), 8'h00, 8'h01, 0);
    expect_out("R6", 1, 1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clear_move;
    apply(13'h0040 | 13'h0007, 8'hC3, 8'h11, 0);
    expect_out("R7", 1, 1, 8'hC3, 0, 0, 0, 0, 0, 0, 0);
    apply(13'h0080, 8'hC3, 8'h11, 0);
    expect_out("R7", 1, 0, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    apply(13'h00C9, 8'hC3, 8'h11, 0);
    expect_out("R7", 1, 1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rotate;
    apply(rop(5'b01100, 0, 6'h04), 8'h00, 8'h81, 0);
    expect_out("R8", 1, 0, 8'h40, 0, 0, 1, 1, 0, 0, 0);
    apply(rop(5'b01100, 1, 6'h04), 8'h00, 8'h02, 1);
    expect_out("R8", 1, 1, 8'h81, 0, 0, 1, 0, 0, 0, 0);
    apply(rop(5'b01101, 0, 6'h04), 8'h00, 8'h81, 0);
    expect_out("R8", 1, 0, 8'h02, 0, 0, 1, 1, 0, 0, 0);
    apply(rop(5'b01101, 1, 6'h04), 8'h00, 8'h40, 1);
    expect_out("R8", 1, 1, 8'h81, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_swap;
    apply(rop(5'b01110, 0, 6'h08), 8'h00, 8'h3C, 1);
    expect_out("R9", 1, 0, 8'hC3, 0, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b01110, 1, 6'h08), 8'hFF, 8'h00, 0);
    expect_out("R9", 1, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_skip_count;
    apply(rop(5'b01011, 0, 6'h09), 8'h00, 8'h01, 0);
    expect_out("R10", 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1);
    apply(rop(5'b01011, 1, 6'h09), 8'h00, 8'h00, 0);
    expect_out("R10", 1, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
    apply(rop(5'b01111, 1, 6'h09), 8'h00, 8'hFF, 0);
    expect_out("R10", 1, 1, 8'h00, 0, 0, 0, 0, 0, 0, 1);
    apply(rop(5'b01111, 0, 6'h09), 8'h00, 8'h7F, 0);
    expect_out("R10", 1, 0, 8'h80, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bits;
    apply(bop(2'b00, 3'd7, 6'h0A), 8'h00, 8'hFF, 0);
    expect_out("R11", 1, 1, 8'h7F, 0, 0, 0, 0, 0, 0, 0);
    apply(bop(2'b01, 3'd0, 6'h0A), 8'h00, 8'h00, 0);
    expect_out("R11", 1, 1, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    apply(bop(2'b01, 3'd4, 6'h0A), 8'h00, 8'h0F, 0);
    expect_out("R11", 1, 1, 8'h1F, 0, 0, 0, 0, 0, 0, 0);
    apply(bop(2'b10, 3'd3, 6'h0A), 8'h00, 8'hF7, 0);
    expect_out("R11", 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1);
    apply(bop(2'b10, 3'd3, 6'h0A), 8'h00, 8'h08, 0);
    expect_out("R11", 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    apply(bop(2'b11, 3'd6, 6'h0A), 8'h00, 8'h40, 0);
    expect_out("R11", 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1);
    apply(bop(2'b11, 3'd6, 6'h0A), 8'h00, 8'hBF, 0);
    expect_out("R11", 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_daa;
    apply(13'h0001, 8'h9A, 8'h00, 0);
    expect_out("R12", 1, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0);
    apply(13'h0001, 8'h3C, 8'h00, 0);
    expect_out("R12", 1, 0, 8'h42, 0, 0, 1, 0, 0, 0, 0);
    apply(13'h0001, 8'h12, 8'h00, 1);
    expect_out("R12", 1, 0, 8'h72, 0, 0, 1, 1, 0, 0, 0);
    apply(13'h0001, 8'h45, 8'h00, 0);
    expect_out("R12", 1, 0, 8'h45, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_noop();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_clear_move();
    t_rotate();
    t_swap();
    t_skip_count();
    t_bits();
    t_daa();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule